// File: doc/BRIEF.md
# GCR Bit-Cell Write Serializer

This block turns a stream of byte-sized words into a single write-data line for a GCR-coded floppy stream. The line carries no clock. Time is divided into cells of a fixed number of system clocks. A cell carrying a 1 starts with a level change, and a cell carrying a 0 leaves the level alone. Because only changes carry meaning, the resting level of the line has no significance.

Words arrive on a valid/ready handshake and each word carries a kind flag. A data word sends eight cells, most significant bit first. A sync word sends a ten-cell fill pattern, ignoring its data field. A receiver that frames bytes on a leading 1 locks onto the byte boundaries after a short run of these fill patterns. The handshake completes only on the final clock of the word being sent, so consecutive words follow each other with no gap.

Once sending has begun, the block never stops. If no word is offered at a word boundary, it sends a fill pattern and raises a sticky underrun flag. Data bytes that would break the code rules are refused and reported.

Top module: `gcr_cell_writer`

## Requirements
- R1: After reset `wr_line` is 0, `in_ready` is 1, and `bad_byte` and `underrun_flag` are 0. Until the first word is accepted, the block stays idle: `in_ready` stays high, the line does not move and no underrun is raised.
- R2: Every cell lasts `CELL_CLKS` clocks (default 16). The line changes only on the first clock of a cell.
- R3: A 1 cell inverts `wr_line` on the first clock of the cell, and a 0 cell leaves it unchanged. Bits go out most significant first.
- R4: A word with `in_mode`=0 sends `in_data` as 8 cells starting with bit 7. A word with `in_mode`=1 sends the 10-cell pattern 1111111100 (eight 1 cells, then two 0 cells) and ignores `in_data`.
- R5: Once sending has begun, `in_ready` is high only on the last clock of the last cell of the current word. A word taken there starts its first cell on the next clock.
- R6: A data word is refused when bit 7 of `in_data` is 0 or when the byte holds three or more adjacent 0 bits. A refused word still completes the handshake. `bad_byte` is high for exactly the clock after that handshake. The refused slot is filled with a sync pattern, or the block stays idle if it has not yet started.
- R7: After sending has begun, if `in_valid` is low at a word boundary, a sync pattern is sent and `underrun_flag` is set. The flag stays set until it is cleared.
- R8: `underrun_clr` clears `underrun_flag` on the next clock. If a new underrun occurs on the same clock as the clear, the flag stays set.
- R9: The line never holds still for more than three cells while sending, so no more than two 0 cells ever follow one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_mode | input | 1 | Word kind: 0 data byte, 1 sync pattern |
| in_data | input | 8 | Data byte, most significant bit sent first |
| in_ready | output | 1 | The offered word is taken on this clock |
| underrun_clr | input | 1 | Clears the underrun flag |
| wr_line | output | 1 | Transition-coded write-data line |
| bad_byte | output | 1 | One-clock pulse after a refused data word |
| underrun_flag | output | 1 | Sticky: a boundary passed with no word offered |

## Verification
The two events that can land on the same clock are an underrun at a word boundary and a clear of the underrun flag. The bench withholds a word exactly at a boundary while pulsing `underrun_clr`. It then requires the flag to remain set and a sync pattern to appear on the line. A second collision puts a refused byte on a boundary while sending is under way. The slot must then carry a fill pattern with no gap, `bad_byte` must pulse, and `underrun_flag` must not be disturbed. Every clock is compared against a cell-level model of the line level and the handshake.

// File: rtl/gcr_cell_pkg.sv
// Shared constants, types and helper functions for the GCR bit-cell
// write serializer. Assumes an 8-bit data byte and a 10-bit fill
// pattern; the fill pattern width sets the shift register width.
package gcr_cell_pkg;

    localparam int DATA_BITS    = 8;
    localparam int SYNC_BITS    = 10;
    localparam int MAX_ZERO_RUN = 2;
    localparam int WORD_BITS    = SYNC_BITS;
    localparam int PAD_BITS     = WORD_BITS - DATA_BITS;
    localparam int LEN_W        = $clog2(WORD_BITS + 1);

    typedef logic [WORD_BITS-1:0] pattern_t;
    typedef logic [LEN_W-1:0]     length_t;

    localparam length_t DATA_LEN = length_t'(DATA_BITS);
    localparam length_t SYNC_LEN = length_t'(SYNC_BITS);

    typedef enum logic {
        WORD_DATA = 1'b0,
        WORD_SYNC = 1'b1
    } word_kind_e;

    typedef struct packed {
        pattern_t pattern;
        length_t  length;
    } cell_word_t;

    // Fill pattern: DATA_BITS ones in the top positions, zeros below.
    function automatic pattern_t sync_pattern();
        pattern_t p;
        for (int i = 0; i < WORD_BITS; i++) begin
            p[i] = (i >= PAD_BITS) ? 1'b1 : 1'b0;
        end
        return p;
    endfunction

    // Data byte left-aligned in the shift register.
    function automatic pattern_t data_pattern(logic [DATA_BITS-1:0] b);
        return {b, {PAD_BITS{1'b0}}};
    endfunction

    // A byte is legal when its top bit is set and no zero run is too long.
    function automatic logic byte_is_legal(logic [DATA_BITS-1:0] b);
        int   run;
        logic ok;
        run = 0;
        ok  = b[DATA_BITS-1];
        for (int i = DATA_BITS - 1; i >= 0; i--) begin
            if (b[i]) begin
                run = 0;
            end else begin
                run = run + 1;
                if (run > MAX_ZERO_RUN) begin
                    ok = 1'b0;
                end
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/gcr_cell_timer.sv
// Cell timer: counts clocks within a bit cell and flags the last clock
// of each cell. Assumes CELL_CLKS >= 2. Held at the first clock while
// the serializer has not started.
module gcr_cell_timer #(
    parameter int CELL_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cell_end
);

    localparam int CNT_W = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CELL_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the in-cell clock counter, wrapping at the cell end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cell_end = run && (cnt == LAST_CNT);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_CNT); // R2

    AST_CELL_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cell_end |=> !cell_end); // R2

    AST_IDLE_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R2

endmodule

// File: rtl/gcr_word_gate.sv
// Word gate: owns the handshake, decides what the next word will be
// (accepted byte, accepted fill, or fill for an underrun or refused
// byte), and keeps the started, refused-byte and underrun flags.
// Assumes word_done marks the final clock of the word now being sent.
module gcr_word_gate
    import gcr_cell_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_done,
    input  logic                 in_valid,
    input  logic                 in_mode,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 underrun_clr,
    output logic                 in_ready,
    output logic                 load,
    output cell_word_t           load_word,
    output logic                 started,
    output logic                 bad_byte,
    output logic                 underrun_flag
);

    word_kind_e kind;
    logic       boundary;
    logic       take;
    logic       legal;
    logic       accept;
    logic       starve;

    assign kind     = word_kind_e'(in_mode);
    assign boundary = !started || word_done;
    assign take     = boundary && in_valid;
    assign legal    = (kind == WORD_SYNC) || byte_is_legal(in_data);
    assign accept   = take && legal;
    assign starve   = boundary && started && !in_valid;
    assign in_ready = boundary;
    assign load     = accept || (boundary && started);

    // Choose the pattern and length of the word loaded at this boundary.
    always_comb begin
        if (accept && (kind == WORD_DATA)) begin
            load_word.pattern = data_pattern(in_data);
            load_word.length  = DATA_LEN;
        end else begin
            load_word.pattern = sync_pattern();
            load_word.length  = SYNC_LEN;
        end
    end

    // Latch that sending has begun; it never stops afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (accept) begin
            started <= 1'b1;
        end
    end

    // One-clock report of a refused data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_byte <= 1'b0;
        end else begin
            bad_byte <= take && !legal;
        end
    end

    // Sticky underrun flag; a new underrun wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun_flag <= 1'b0;
        end else if (starve) begin
            underrun_flag <= 1'b1;
        end else if (underrun_clr) begin
            underrun_flag <= 1'b0;
        end
    end

    AST_STARTED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> started); // R1

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_flag && !underrun_clr) |=> underrun_flag); // R8

    AST_UNDERRUN_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_flag |-> started); // R7

    AST_BAD_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_byte |-> $past(in_ready && in_valid && !in_mode)); // R6

    AST_IDLE_REFUSE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && in_valid && !in_mode && !in_data[DATA_BITS-1]) |-> !load); // R6

endmodule

// File: rtl/gcr_bit_shifter.sv
// Bit shifter: holds the word being sent, steps to the next bit at each
// cell end, and drives the transition-coded line. Assumes load is only
// raised at a word boundary and carries a nonzero length.
module gcr_bit_shifter
    import gcr_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  cell_word_t load_word,
    input  logic       cell_end,
    output logic       last_bit,
    output logic       wr_line
);

    localparam int MSB = WORD_BITS - 1;

    pattern_t   shreg;
    length_t    bits_left;
    logic [1:0] zero_cells;

    assign last_bit = (bits_left == length_t'(1));

    // Load a new word or move on to the next bit of the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (load) begin
            shreg     <= load_word.pattern;
            bits_left <= load_word.length;
        end else if (cell_end && !last_bit) begin
            shreg     <= {shreg[MSB-1:0], 1'b0};
            bits_left <= bits_left - 1'b1;
        end
    end

    // Invert the line at the start of every cell that carries a 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_line <= 1'b0;
        end else if (load) begin
            wr_line <= wr_line ^ load_word.pattern[MSB];
        end else if (cell_end && !last_bit) begin
            wr_line <= wr_line ^ shreg[MSB-1];
        end
    end

    // Count finished 0 cells in a row, saturating, for the run check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_cells <= '0;
        end else if (cell_end) begin
            if (shreg[MSB]) begin
                zero_cells <= '0;
            end else if (zero_cells != 2'b11) begin
                zero_cells <= zero_cells + 1'b1;
            end
        end
    end

    AST_TOGGLE_IS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (load || (cell_end && !last_bit)) |=> ((wr_line ^ $past(wr_line)) == shreg[MSB])); // R3

    AST_ZERO_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cells <= 2'(MAX_ZERO_RUN)); // R9

    AST_LOAD_HAS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bits_left != '0)); // R4

endmodule

// File: rtl/gcr_cell_writer.sv
// GCR bit-cell write serializer top: connects the word gate, cell timer
// and bit shifter. Assumes all inputs are synchronous to clk.
module gcr_cell_writer
    import gcr_cell_pkg::*;
#(
    parameter int CELL_CLKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_mode,
    input  logic [DATA_BITS-1:0] in_data,
    output logic                 in_ready,
    input  logic                 underrun_clr,
    output logic                 wr_line,
    output logic                 bad_byte,
    output logic                 underrun_flag
);

    logic       cell_end;
    logic       last_bit;
    logic       word_done;
    logic       load;
    logic       started;
    cell_word_t load_word;

    assign word_done = cell_end && last_bit;

    gcr_word_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_done     (word_done),
        .in_valid      (in_valid),
        .in_mode       (in_mode),
        .in_data       (in_data),
        .underrun_clr  (underrun_clr),
        .in_ready      (in_ready),
        .load          (load),
        .load_word     (load_word),
        .started       (started),
        .bad_byte      (bad_byte),
        .underrun_flag (underrun_flag)
    );

    gcr_cell_timer #(
        .CELL_CLKS (CELL_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (started),
        .cell_end (cell_end)
    );

    gcr_bit_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .cell_end  (cell_end),
        .last_bit  (last_bit),
        .wr_line   (wr_line)
    );

    AST_WORD_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> load); // R5

    AST_LINE_AT_CELL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cell_end) |=> $stable(wr_line)); // R2

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> in_ready); // R1

endmodule

// File: tb/gcr_cell_writer_test.sv
module gcr_cell_writer_test;

    localparam int CELL = 16;
    localparam logic [9:0] FILL = 10'b1111111100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_mode = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       underrun_clr = 1'b0;
    logic       in_ready, wr_line, bad_byte, underrun_flag;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    // cell-level model state
    bit         m_started = 1'b0;
    int         m_cnt = 0;
    int         m_left = 0;
    logic [9:0] m_bits = '0;
    logic       m_line = 1'b0;
    logic       m_under = 1'b0;
    logic       m_err = 1'b0;
    int         quiet = 0;
    logic       prev_line = 1'b0;

    always #5 clk = ~clk;

    gcr_cell_writer #(.CELL_CLKS(CELL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_data(in_data), .in_ready(in_ready), .underrun_clr(underrun_clr),
        .wr_line(wr_line), .bad_byte(bad_byte), .underrun_flag(underrun_flag)
    );

    // R6 rule: top bit set and no 3-bit window of zeros.
    function automatic bit exp_legal(logic [7:0] b);
        for (int i = 0; i <= 5; i++) begin
            if (b[i +: 3] == 3'b000) return 1'b0;
        end
        return b[7];
    endfunction

    function automatic bit model_ready();
        return !m_started || (m_cnt == CELL - 1 && m_left == 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_ports();
        check(wr_line === m_line, "R3 line level", int'(wr_line), int'(m_line));
        check(in_ready === model_ready(), "R5 in_ready", int'(in_ready), int'(model_ready()));
        check(underrun_flag === m_under, "R7 underrun_flag", int'(underrun_flag), int'(m_under));
        check(bad_byte === m_err, "R6 bad_byte", int'(bad_byte), int'(m_err));
        if (m_started) begin
            if (wr_line !== prev_line) quiet = 0;
            else quiet++;
            check(quiet < 3 * CELL, "R9 quiet clocks", quiet, 3 * CELL - 1);
        end else begin
            check(wr_line === 1'b0, "R1 idle line", int'(wr_line), 0);
        end
        prev_line = wr_line;
    endtask

    // Compare, drive one clock of inputs, advance the model past the edge.
    task automatic do_cycle(bit v, bit m, logic [7:0] d, bit c);
        bit rdy, take, ok, good;
        compare_ports();
        in_valid = v; in_mode = m; in_data = d; underrun_clr = c;
        rdy  = model_ready();
        take = rdy && v;
        ok   = m ? 1'b1 : exp_legal(d);
        good = take && ok;
        if (rdy && m_started && !v) m_under = 1'b1;
        else if (c) m_under = 1'b0;
        m_err = take && !ok;
        if (good || (rdy && m_started)) begin
            if (good && !m) begin
                m_bits = {d, 2'b00}; m_left = 8;
            end else begin
                m_bits = FILL; m_left = 10;
            end
            m_line    = m_line ^ m_bits[9];
            m_cnt     = 0;
            m_started = 1'b1;
        end else if (m_started) begin
            if (m_cnt == CELL - 1) begin
                m_cnt  = 0;
                m_bits = m_bits << 1;
                m_left--;
                m_line = m_line ^ m_bits[9];
            end else begin
                m_cnt++;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // Wait for the next boundary, then present the given inputs on it.
    task automatic push(bit v, bit m, logic [7:0] d, bit c);
        while (!model_ready()) do_cycle(1'b0, 1'b0, 8'h00, ($urandom % 60) == 0);
        do_cycle(v, m, d, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int n;
        logic p;
        void'($urandom(32'h5EED_0C47));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(wr_line === 1'b0, "R1 reset wr_line", int'(wr_line), 0);
        check(in_ready === 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        check(bad_byte === 1'b0, "R1 reset bad_byte", int'(bad_byte), 0);
        check(underrun_flag === 1'b0, "R1 reset underrun_flag", int'(underrun_flag), 0);
        for (int i = 0; i < 20; i++) do_cycle(1'b0, 1'b0, 8'h00, i[0]);
        check(underrun_flag === 1'b0, "R1 no underrun while idle", int'(underrun_flag), 0);

        // R6 refusals while idle: top bit clear, then a long zero run
        do_cycle(1'b1, 1'b0, 8'h55, 1'b0);
        check(bad_byte === 1'b1, "R6 idle refuse 55", int'(bad_byte), 1);
        check(in_ready === 1'b1, "R6 still idle", int'(in_ready), 1);
        do_cycle(1'b1, 1'b0, 8'h88, 1'b0);
        check(bad_byte === 1'b1, "R6 idle refuse 88", int'(bad_byte), 1);

        // R4 prologue: five fills with junk data, then D5 AA 96
        for (int i = 0; i < 5; i++) push(1'b1, 1'b1, 8'($urandom), 1'b0);
        push(1'b1, 1'b0, 8'hD5, 1'b0);
        push(1'b1, 1'b0, 8'hAA, 1'b0);
        push(1'b1, 1'b0, 8'h96, 1'b0);

        // R2 cell length measured between two 1 cells
        push(1'b1, 1'b0, 8'hFF, 1'b0);
        n = 0;
        p = wr_line;
        do begin
            do_cycle(1'b0, 1'b0, 8'h00, 1'b0);
            n++;
        end while (wr_line === p && n < 100);
        check(n == CELL, "R2 cell length", n, CELL);

        // R7 underrun, R8 clear off-boundary, R8 collision
        push(1'b0, 1'b0, 8'h00, 1'b0);
        check(underrun_flag === 1'b1, "R7 underrun set", int'(underrun_flag), 1);
        do_cycle(1'b0, 1'b0, 8'h00, 1'b1);
        check(underrun_flag === 1'b0, "R8 clear", int'(underrun_flag), 0);
        push(1'b0, 1'b0, 8'h00, 1'b1);
        check(underrun_flag === 1'b1, "R8 set beats clear", int'(underrun_flag), 1);
        do_cycle(1'b0, 1'b0, 8'h00, 1'b1);

        // R6 refusal while running, then legal edge bytes (R9)
        push(1'b1, 1'b0, 8'h7F, 1'b0);
        check(bad_byte === 1'b1, "R6 running refuse", int'(bad_byte), 1);
        check(underrun_flag === 1'b0, "R6 no underrun from refusal", int'(underrun_flag), 0);
        push(1'b1, 1'b0, 8'h99, 1'b0);
        push(1'b1, 1'b0, 8'hFC, 1'b0);
        push(1'b1, 1'b1, 8'h00, 1'b0);
        push(1'b1, 1'b0, 8'h92, 1'b0);

        // random mix
        for (int i = 0; i < 200; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 8) begin
                push(1'b0, 1'b0, 8'h00, ($urandom % 2) == 1);
            end else if (r < 16) begin
                push(1'b1, 1'b0, 8'($urandom) & 8'h7F, 1'b0);
            end else if (r < 36) begin
                push(1'b1, 1'b1, 8'($urandom), 1'b0);
            end else begin
                do b = 8'($urandom) | 8'h80; while (!exp_legal(b));
                push(1'b1, 1'b0, b, 1'b0);
            end
        end
        for (int i = 0; i < 3 * CELL; i++) do_cycle(1'b1, 1'b1, 8'h00, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule